// File: doc/BRIEF.md
# BCD Watchdog and Interval Timer

This block counts down a period written in hundredths of a second, held as four packed-BCD digits. The smallest period is 00.01 s and the largest is 99.99 s. The count moves only on cycles where the 100 Hz tick enable is high. When the last hundredth runs out, the block raises an interrupt.

The mode input selects one of two behaviours:
- **Watchdog (mode low).** Software must rewrite a period byte before expiry. If it does not, the interrupt latches and stays high until the next write.
- **Interval timer (mode high).** The block reloads the period on every expiry and pulses the interrupt for one clock each time.

A period of 00.00 keeps the block idle.

Top module: `bcd_wdt_timer`

## Requirements
- R1: After reset the interrupt is low and the stored period and the count are 00.00, so the block stays silent until a period is written.
- R2: A write with `wr_sel`=0 replaces the hundredths byte and with `wr_sel`=1 replaces the seconds byte. Each byte is packed BCD with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R3: Every write loads the count from the whole period, including the byte just written, and clears the interrupt in the following cycle.
- R4: The count changes only on cycles with `tick` high; cycles without a tick leave the remaining time unchanged.
- R5: The count decrements with decimal borrow across digits and across the byte boundary, so a period of 01.00 expires on exactly the 100th tick.
- R6: With the mode low, `irq` goes high in the cycle after the tick that exhausts a period of P hundredths (the P-th tick after the write), and stays high until the next write.
- R7: With the mode high, `irq` is high for exactly one cycle after every P-th tick, and the period reloads without software action.
- R8: With a period of 00.00, `irq` never rises in either mode, whatever the ticks.
- R9: A period of 00.01 expires on the first tick, and a period of 99.99 expires on the 9999th tick.
- R10: A tick in the same cycle as a write is ignored; counting starts with the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 100 Hz count enable, one cycle wide |
| wr_en | input | 1 | Period byte write strobe |
| wr_sel | input | 1 | Byte select: 0 hundredths, 1 seconds |
| wr_data | input | 8 | Packed-BCD byte to write |
| interval_mode | input | 1 | 0 watchdog (sticky interrupt), 1 interval (auto reload, pulse) |
| irq | output | 1 | Expiry interrupt |

## Verification
The bench builds the block with its default of four digits. That default makes the full 00.01 to 99.99 range reachable, including the 9999-tick maximum and the borrow from the seconds byte into the hundredths byte. Because the tick is driven almost every cycle, even the longest period runs out well within the run. The random phase then mixes writes to either byte, mode changes and gaps in the tick against an integer model of the remaining time.

// File: rtl/bcd_wdt_timer.sv
module bcd_wdt_timer #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [7:0]          wr_data,
  input  logic                interval_mode,
  output logic                irq
);
  localparam int W  = 4 * DIGITS;
  localparam int NB = DIGITS / 2;

  logic [W-1:0] period_q, count_q, period_new, count_dec;
  logic [DIGITS:0] borrow;
  logic irq_q;

  genvar b, i;
  generate
    for (b = 0; b < NB; b++) begin : g_byte
      assign period_new[8*b +: 8] = (wr_en && (int'(wr_sel) == b)) ? wr_data : period_q[8*b +: 8];
    end
  endgenerate

  assign borrow[0] = 1'b1;
  generate
    for (i = 0; i < DIGITS; i++) begin : g_dig
      logic [3:0] nib;
      assign nib = count_q[4*i +: 4];
      assign count_dec[4*i +: 4] = !borrow[i] ? nib : (nib == 4'd0) ? 4'd9 : nib - 4'd1;
      assign borrow[i+1] = borrow[i] && (nib == 4'd0);
    end
  endgenerate

  wire running = |count_q;
  wire last    = (count_q == W'(1));
  wire expire  = tick && !wr_en && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      count_q  <= '0;
      irq_q    <= 1'b0;
    end else if (wr_en) begin
      period_q <= period_new;
      count_q  <= period_new;
      irq_q    <= 1'b0;
    end else begin
      if (tick && running)
        count_q <= last ? (interval_mode ? period_q : '0) : count_dec;
      irq_q <= expire || (irq_q && !interval_mode);
    end
  end

  assign irq = irq_q;
endmodule

module bcd_wdt_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wr_en,
  input logic         interval_mode,
  input logic         irq,
  input logic [W-1:0] count_q,
  input logic [W-1:0] period_q
);
  a_r3_write_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !irq);
  a_r3_write_loads_count: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count_q == period_q));
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(count_q) && $stable(period_q)));
  a_r6_rise_on_last_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(tick) && ($past(count_q) == W'(1))));
  a_r6_sticky_watchdog: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !interval_mode && !wr_en) |=> irq);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && interval_mode && !(tick && count_q == W'(1))) |=> !irq);
  a_r7_auto_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_mode && tick && !wr_en && count_q == W'(1)) |=> (count_q == period_q));
  a_r8_zero_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == '0) |-> (count_q == '0));
endmodule

bind bcd_wdt_timer bcd_wdt_timer_chk #(.W(4 * DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
  .interval_mode(interval_mode), .irq(irq), .count_q(count_q), .period_q(period_q)
);

// File: tb/bcd_wdt_timer_bench.sv
module bcd_wdt_timer_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, interval_mode = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic irq;
  int checks = 0, failures = 0;
  logic [7:0] m_hund = 8'h00, m_sec = 8'h00;
  int m_rem = 0;
  logic m_irq = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bcd_wdt_timer u_bcd_wdt_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .interval_mode(interval_mode), .irq(irq)
  );

  function automatic int bcd2int(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] rand_bcd();
    logic [3:0] hi, lo;
    hi = 4'($urandom % 10);
    lo = 4'($urandom % 10);
    return {hi, lo};
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: irq actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    check(irq === exp, tag, int'(irq), int'(exp));
  endtask

  task automatic cyc(input logic t, input logic w, input logic s, input logic [7:0] d,
                     input logic m, input string tag);
    tick = t; wr_en = w; wr_sel = s; wr_data = d; interval_mode = m;
    @(posedge clk);
    if (w) begin
      if (s) m_sec = d; else m_hund = d;
      m_rem = bcd2int(m_sec) * 100 + bcd2int(m_hund);
      m_irq = 1'b0;
    end else if (t && m_rem > 0) begin
      if (m_rem == 1) begin
        m_irq = 1'b1;
        m_rem = m ? bcd2int(m_sec) * 100 + bcd2int(m_hund) : 0;
      end else begin
        m_rem--;
        m_irq = m_irq && !m;
      end
    end else begin
      m_irq = m_irq && !m;
    end
    #(CLK_P/4);
    check(irq === m_irq, tag, int'(irq), int'(m_irq));
  endtask

  task automatic wr(input logic s, input logic [7:0] d, input logic m, input string tag);
    cyc(1'b0, 1'b1, s, d, m, tag);
  endtask

  task automatic ticks(input int n, input logic m, input string tag);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 1'b0, 8'h00, m, tag);
  endtask

  initial begin
    #(CLK_P * 190000);
    failures++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #(CLK_P/4);
    expect_irq(1'b0, "R1");
    rst_n = 1'b1;
    ticks(20, 1'b0, "R1");
    expect_irq(1'b0, "R1");

    wr(1'b0, 8'h05, 1'b0, "R2");
    wr(1'b1, 8'h00, 1'b0, "R2");
    ticks(4, 1'b0, "R6");
    expect_irq(1'b0, "R6");
    ticks(1, 1'b0, "R6");
    expect_irq(1'b1, "R6");
    ticks(10, 1'b0, "R6");
    expect_irq(1'b1, "R6");
    wr(1'b0, 8'h05, 1'b0, "R3");
    expect_irq(1'b0, "R3");

    ticks(3, 1'b0, "R4");
    for (int k = 0; k < 20; k++) cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R4");
    expect_irq(1'b0, "R4");
    ticks(1, 1'b0, "R4");
    expect_irq(1'b0, "R4");
    ticks(1, 1'b0, "R4");
    expect_irq(1'b1, "R4");

    wr(1'b1, 8'h01, 1'b0, "R2");
    ticks(104, 1'b0, "R2");
    expect_irq(1'b0, "R2");
    ticks(1, 1'b0, "R2");
    expect_irq(1'b1, "R2");

    wr(1'b0, 8'h00, 1'b0, "R5");
    ticks(99, 1'b0, "R5");
    expect_irq(1'b0, "R5");
    ticks(1, 1'b0, "R5");
    expect_irq(1'b1, "R5");

    wr(1'b1, 8'h00, 1'b1, "R7");
    wr(1'b0, 8'h03, 1'b1, "R7");
    for (int k = 0; k < 3; k++) begin
      ticks(2, 1'b1, "R7");
      expect_irq(1'b0, "R7");
      ticks(1, 1'b1, "R7");
      expect_irq(1'b1, "R7");
    end
    cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "R7");
    expect_irq(1'b0, "R7");

    wr(1'b0, 8'h00, 1'b1, "R8");
    ticks(300, 1'b1, "R8");
    expect_irq(1'b0, "R8");
    ticks(300, 1'b0, "R8");
    expect_irq(1'b0, "R8");

    wr(1'b0, 8'h01, 1'b0, "R9");
    ticks(1, 1'b0, "R9");
    expect_irq(1'b1, "R9");
    wr(1'b1, 8'h99, 1'b0, "R9");
    wr(1'b0, 8'h99, 1'b0, "R9");
    ticks(9998, 1'b0, "R9");
    expect_irq(1'b0, "R9");
    ticks(1, 1'b0, "R9");
    expect_irq(1'b1, "R9");

    wr(1'b1, 8'h00, 1'b0, "R10");
    cyc(1'b1, 1'b1, 1'b0, 8'h02, 1'b0, "R10");
    ticks(1, 1'b0, "R10");
    expect_irq(1'b0, "R10");
    ticks(1, 1'b0, "R10");
    expect_irq(1'b1, "R10");

    begin
      logic m = 1'b0;
      for (int k = 0; k < 30000; k++) begin
        int r = int'($urandom % 100);
        if (r < 1) m = ~m;
        if (r >= 96) begin
          logic s = 1'($urandom % 2);
          logic [7:0] d = rand_bcd();
          if (s && ($urandom % 4 != 0)) d = 8'h00;
          cyc(1'($urandom % 2), 1'b1, s, d, m, m ? "R7" : "R6");
        end else begin
          cyc(($urandom % 3) != 0, 1'b0, 1'b0, 8'h00, m, m ? "R7" : "R6");
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule